// File: doc/BRIEF.md
# Redundant-Channel Single-Shot Transmit Sequencer

This block sends one message over a set of redundant bus channels. Every channel carries the same copy, and each copy starts a fixed interval after the copy on the channel before it. When a trigger arrives, the block captures the payload and writes it into every channel's message object in a single load cycle. It then serves the channels strictly in ascending order. For each channel it raises that channel's transmit request and watches the controller's start indication against a short timeout. It withdraws the request as soon as the check resolves, which keeps the controller from queueing a retransmission. It then holds off until the inter-channel delay has run out before it moves to the next channel.

All timing is counted in bit-time ticks, taken from a strobe input. The timeout window and the channel-to-channel delay are compile-time parameters, and the delay must exceed the timeout. When the sequence ends, the block reports which channels never started, through an error vector that stays valid until the next trigger, and it raises a one-cycle done pulse. A trigger that arrives during a sequence is dropped and sets a sticky overrun flag.

Top module: `rep_tx_sequencer`

## Requirements
- R1: A trigger accepted while idle captures `payload_i`. In the next cycle every bit of `ld_en_o` is high for exactly one cycle, `ld_data_o` equals the captured payload, and no transmit request has yet been raised in that sequence.
- R2: In each sequence `tx_req_o[k]` (bit k = channel k) is raised exactly once per channel, in order 0, 1, ..., NUM_CH-1. At most one bit of `tx_req_o` is high in any cycle.
- R3: When `tx_started_i[k]` is sampled high while `tx_req_o[k]` is high, the request is low in the next cycle and `err_o[k]` stays 0. The request is therefore high for exactly as many cycles as the controller took to answer.
- R4: A tick is counted in a cycle if `bit_tick_i` is high in that cycle. If no start indication arrives while a request is high, the request is withdrawn once T_TICKS ticks have been counted over the cycles in which it was high, and `err_o[k]` is set to 1.
- R5: The request for channel k+1 is raised once D_TICKS ticks have been counted since the cycle in which channel k's request was raised. D_TICKS is greater than T_TICKS, so every request is withdrawn before the next one rises.
- R6: After the last channel's delay window ends, `done_o` is high for exactly one cycle and `busy_o` is low in that cycle. `err_o` is cleared when a trigger is accepted and is otherwise held until the next accepted trigger.
- R7: A trigger while `busy_o` is high is ignored: it causes no reload and no restart, and the sequence in progress completes unchanged. It sets `overrun_o`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | One-cycle strobe per bit time |
| start_i | input | 1 | Trigger for one replicated transmission |
| payload_i | input | PAYLOAD_W | Message payload, captured on an accepted trigger |
| ld_data_o | output | PAYLOAD_W | Payload written into the channel message objects |
| ld_en_o | output | NUM_CH | Per-channel load strobes for the message objects |
| tx_req_o | output | NUM_CH | Per-channel transmit request |
| tx_started_i | input | NUM_CH | Per-channel indication that transmission began |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when all channels have been attempted |
| err_o | output | NUM_CH | Per-channel flag: start not seen within the timeout |
| overrun_o | output | 1 | Sticky flag: a trigger arrived while busy |

## Verification
The assertions check the following on every cycle:
- at most one request is high;
- a request drops the cycle after its start indication;
- the sequencer leaves the request phase once the timeout count is reached;
- the timeout always resolves before the delay window closes;
- the load cycle leads straight into channel 0;
- done is a single-cycle pulse;
- the error vector and the overrun flag hold their values.

Only the bench scenarios can show the rest. These are the tick counts measured between successive request edges and from request rise to a timeout fall, a payload that matches the value at the trigger, and the exact error pattern for mixed answers from the controllers. They also cover a trigger dropped in the middle of a sequence and a change of tick rate.

// File: rtl/rtxs_pkg.sv
package rtxs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_REQ  = 2'd2,
    ST_GAP  = 2'd3
  } rtxs_state_e;
endpackage

// File: rtl/rtxs_tick_timer.sv
module rtxs_tick_timer #(
  parameter int unsigned MAX_TICKS = 5,
  parameter int unsigned CNT_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_TICKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (tick_i && cnt_q != MAX_CNT) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtxs_seq_fsm.sv
module rtxs_seq_fsm
  import rtxs_pkg::*;
#(
  parameter int unsigned NUM_CH  = 3,
  parameter int unsigned T_TICKS = 2,
  parameter int unsigned D_TICKS = 5,
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned IDX_W   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             started_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             accept_o,
  output logic             load_o,
  output logic             req_act_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             timer_clr_o,
  output logic             err_set_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] T_CNT    = CNT_W'(T_TICKS);
  localparam logic [CNT_W-1:0] D_CNT    = CNT_W'(D_TICKS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CH - 1);

  rtxs_state_e      st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;

  always_comb begin
    st_d        = st_q;
    idx_d       = idx_q;
    done_d      = 1'b0;
    accept_o    = 1'b0;
    timer_clr_o = 1'b0;
    err_set_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          idx_d    = '0;
          st_d     = ST_LOAD;
        end
      end
      ST_LOAD: begin
        timer_clr_o = 1'b1;
        st_d        = ST_REQ;
      end
      ST_REQ: begin
        if (started_i) begin
          st_d = ST_GAP;
        end else if (cnt_i >= T_CNT) begin
          err_set_o = 1'b1;
          st_d      = ST_GAP;
        end
      end
      ST_GAP: begin
        // delay window measured from this channel's request rise
        if (cnt_i >= D_CNT) begin
          if (idx_q == LAST_IDX) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            idx_d       = idx_q + 1'b1;
            timer_clr_o = 1'b1;
            st_d        = ST_REQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      done_q <= done_d;
    end
  end

  assign load_o    = (st_q == ST_LOAD);
  assign req_act_o = (st_q == ST_REQ);
  assign idx_o     = idx_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;

  assert_load_then_first_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOAD) |=> (st_q == ST_REQ && idx_q == '0));

  assert_in_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_GAP && st_d == ST_REQ) |=> (idx_q == IDX_W'($past(idx_q) + 1'b1)));

  assert_timeout_exit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REQ && cnt_i >= T_CNT) |=> (st_q == ST_GAP));

  // D > T: a timeout always resolves inside the delay window
  assert_gap_after_timeout_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REQ && st_d == ST_GAP) |-> (cnt_i < D_CNT));

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (st_q == ST_IDLE));
endmodule

// File: rtl/rtxs_chan_bank.sv
module rtxs_chan_bank #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_act_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              err_set_i,
  input  logic              err_clr_i,
  input  logic [NUM_CH-1:0] tx_started_i,
  output logic [NUM_CH-1:0] tx_req_o,
  output logic              started_sel_o,
  output logic [NUM_CH-1:0] err_o
);
  logic [NUM_CH-1:0] err_q;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    logic sel;
    assign sel         = (idx_i == IDX_W'(k));
    assign tx_req_o[k] = req_act_i && sel;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                err_q[k] <= 1'b0;
      else if (err_clr_i)         err_q[k] <= 1'b0;
      else if (err_set_i && sel)  err_q[k] <= 1'b1;
    end

    assert_err_only_timeout_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(err_q[k]) |-> ($past(tx_req_o[k]) && !$past(tx_started_i[k])));
  end

  assign started_sel_o = |(tx_req_o & tx_started_i);
  assign err_o         = err_q;

  assert_req_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tx_req_o));

  assert_withdraw_on_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(tx_req_o & tx_started_i)) |=> (tx_req_o == '0));
endmodule

// File: rtl/rep_tx_sequencer.sv
module rep_tx_sequencer #(
  parameter int unsigned NUM_CH    = 3,
  parameter int unsigned PAYLOAD_W = 32,
  parameter int unsigned T_TICKS   = 2,
  parameter int unsigned D_TICKS   = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_tick_i,
  input  logic                 start_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  output logic [PAYLOAD_W-1:0] ld_data_o,
  output logic [NUM_CH-1:0]    ld_en_o,
  output logic [NUM_CH-1:0]    tx_req_o,
  input  logic [NUM_CH-1:0]    tx_started_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [NUM_CH-1:0]    err_o,
  output logic                 overrun_o
);
  localparam int unsigned CNT_W = $clog2(D_TICKS + 1);
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic                 accept, load, req_act, timer_clr, err_set, started_sel;
  logic [IDX_W-1:0]     idx;
  logic [CNT_W-1:0]     cnt;
  logic [PAYLOAD_W-1:0] payload_q;
  logic                 overrun_q;

  rtxs_tick_timer #(.MAX_TICKS(D_TICKS), .CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (timer_clr),
    .tick_i (bit_tick_i),
    .cnt_o  (cnt)
  );

  rtxs_seq_fsm #(
    .NUM_CH(NUM_CH), .T_TICKS(T_TICKS), .D_TICKS(D_TICKS),
    .CNT_W(CNT_W), .IDX_W(IDX_W)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .started_i   (started_sel),
    .cnt_i       (cnt),
    .accept_o    (accept),
    .load_o      (load),
    .req_act_o   (req_act),
    .idx_o       (idx),
    .timer_clr_o (timer_clr),
    .err_set_o   (err_set),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  rtxs_chan_bank #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_act_i     (req_act),
    .idx_i         (idx),
    .err_set_i     (err_set),
    .err_clr_i     (accept),
    .tx_started_i  (tx_started_i),
    .tx_req_o      (tx_req_o),
    .started_sel_o (started_sel),
    .err_o         (err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     payload_q <= '0;
    else if (accept) payload_q <= payload_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                overrun_q <= 1'b0;
    else if (start_i && busy_o) overrun_q <= 1'b1;
  end

  assign ld_data_o = payload_q;
  assign ld_en_o   = {NUM_CH{load}};
  assign overrun_o = overrun_q;

  assert_err_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(err_o));

  assert_overrun_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> overrun_o);

  assert_overrun_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: tb/tb_rep_tx_sequencer.sv
`timescale 1ns/1ps
module tb_rep_tx_sequencer;
  localparam int NCH = 3;
  localparam int PW  = 32;
  localparam int TT  = 2;
  localparam int DT  = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_tick = 1'b0;
  logic start = 1'b0;
  logic [PW-1:0]  payload = '0;
  logic [PW-1:0]  ld_data;
  logic [NCH-1:0] ld_en, tx_req, err, started = '0;
  logic busy, done, overrun;

  always #2.5 clk = ~clk;

  rep_tx_sequencer #(.NUM_CH(NCH), .PAYLOAD_W(PW), .T_TICKS(TT), .D_TICKS(DT)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_tick_i(bit_tick), .start_i(start),
    .payload_i(payload), .ld_data_o(ld_data), .ld_en_o(ld_en), .tx_req_o(tx_req),
    .tx_started_i(started), .busy_o(busy), .done_o(done), .err_o(err), .overrun_o(overrun)
  );

  int checks = 0, failures = 0;
  int tick_period = 4, phase = 0;
  int tick_total = 0, last_tick = 0;
  int dly [NCH];
  int req_len [NCH], fall_ticks [NCH], gap_meas [NCH];
  int rise_n, rise_mark, order_bad, multi_hot, ld_n, ld_bad, ld_late, done_n, done_wide;
  logic [PW-1:0]  ld_seen;
  logic [NCH-1:0] err_at_ld, prev_req;
  logic prev_done;

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    rise_n = 0; rise_mark = 0; order_bad = 0; multi_hot = 0;
    ld_n = 0; ld_bad = 0; ld_late = 0; done_n = 0; done_wide = 0;
    ld_seen = '0; err_at_ld = '0;
    for (int k = 0; k < NCH; k++) begin
      req_len[k] = 0; fall_ticks[k] = -1; gap_meas[k] = -1;
    end
  endtask

  // monitor, controller responders and tick source; one process at the falling edge
  initial begin
    clear_mon();
    prev_req = '0; prev_done = 1'b0;
    for (int k = 0; k < NCH; k++) dly[k] = 0;
    forever begin
      @(negedge clk);
      if (ld_en != '0) begin
        ld_n++;
        ld_seen = ld_data;
        err_at_ld = err;
        if (ld_en != '1) ld_bad++;
        if (rise_n != 0) ld_late++;
      end
      if ($countones(tx_req) > 1) multi_hot++;
      for (int k = 0; k < NCH; k++) begin
        if (tx_req[k] && !prev_req[k]) begin
          if (k != rise_n) order_bad++;
          if (rise_n > 0 && rise_n <= NCH) gap_meas[rise_n-1] = tick_total - last_tick - rise_mark;
          rise_mark = tick_total;
          rise_n++;
        end
        if (tx_req[k]) req_len[k]++;
        if (!tx_req[k] && prev_req[k]) fall_ticks[k] = tick_total - last_tick - rise_mark;
      end
      if (done) begin
        done_n++;
        if (prev_done) done_wide++;
      end
      prev_req  = tx_req;
      prev_done = done;
      for (int k = 0; k < NCH; k++)
        started[k] <= tx_req[k] && (dly[k] != 0) && (req_len[k] == dly[k]);
      last_tick = (phase == 0) ? 1 : 0;
      bit_tick <= (phase == 0);
      tick_total += last_tick;
      phase = (phase + 1) % tick_period;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    start  = 1'b0;
    step(3);
    rst_ni = 1'b1;
    step(2);
  endtask

  // runs one sequence; a nonzero delay answers after that many request cycles, 0 never answers
  task automatic run_seq(input logic [PW-1:0] pl, input int d0, input int d1, input int d2,
                         input bit inject, input logic [PW-1:0] pl2);
    dly[0] = d0; dly[1] = d1; dly[2] = d2;
    clear_mon();
    payload = pl;
    start   = 1'b1;
    step(1);
    start   = 1'b0;
    payload = ~pl;
    if (inject) begin
      for (int i = 0; i < 200 && rise_n < 2; i++) step(1);
      payload = pl2;
      start   = 1'b1;
      step(1);
      start   = 1'b0;
    end
    for (int i = 0; i < 2000 && done_n == 0; i++) step(1);
    chk(done_n == 1, "R6", "done seen", done_n, 1);
  endtask

  task automatic check_run(input string tag, input logic [PW-1:0] pl, input logic [NCH-1:0] exp_err);
    $display("-- %s", tag);
    chk(ld_n == 1 && ld_bad == 0, "R1", "single full-width load", ld_n, 1);
    chk(ld_seen == pl, "R1", "load data", ld_seen, pl);
    chk(ld_late == 0, "R1", "load before requests", ld_late, 0);
    chk(err_at_ld == '0, "R6", "err cleared at trigger", err_at_ld, 0);
    chk(rise_n == NCH, "R2", "request count", rise_n, NCH);
    chk(order_bad == 0, "R2", "request order", order_bad, 0);
    chk(multi_hot == 0, "R2", "one request at a time", multi_hot, 0);
    for (int k = 0; k < NCH; k++) begin
      if (exp_err[k]) chk(fall_ticks[k] == TT, "R4", $sformatf("timeout ticks ch%0d", k), fall_ticks[k], TT);
      else            chk(req_len[k] == dly[k], "R3", $sformatf("request cycles ch%0d", k), req_len[k], dly[k]);
    end
    for (int k = 0; k < NCH - 1; k++)
      chk(gap_meas[k] == DT, "R5", $sformatf("stagger ticks ch%0d->ch%0d", k, k + 1), gap_meas[k], DT);
    chk(err == exp_err, "R4", "error vector", err, exp_err);
    chk(done_wide == 0, "R6", "done width", done_wide, 0);
    chk(busy == 1'b0, "R6", "idle after done", busy, 0);
  endtask

  task automatic t_reset_state();
    $display("-- reset state");
    chk(tx_req == '0 && ld_en == '0, "R2", "no request or load after reset", {tx_req, ld_en}, 0);
    chk(busy == 0 && done == 0, "R6", "idle after reset", {busy, done}, 0);
    chk(err == '0, "R4", "err after reset", err, 0);
    chk(overrun == 0, "R7", "overrun after reset", overrun, 0);
  endtask

  task automatic t_all_start();
    run_seq(32'hA5A5_1234, 1, 3, 2, 1'b0, '0);
    check_run("all channels start (R3)", 32'hA5A5_1234, 3'b000);
  endtask

  task automatic t_all_timeout();
    run_seq(32'hDEAD_BEEF, 0, 0, 0, 1'b0, '0);
    check_run("all channels time out (R4)", 32'hDEAD_BEEF, 3'b111);
  endtask

  task automatic t_mixed();
    run_seq(32'h0F0F_00FF, 2, 0, 3, 1'b0, '0);
    check_run("middle channel silent (R4 R5)", 32'h0F0F_00FF, 3'b010);
  endtask

  task automatic t_err_hold();
    logic [NCH-1:0] e0;
    e0 = err;
    step(25);
    chk(err == e0, "R6", "err held while idle", err, e0);
    chk(done_n == 1, "R6", "no extra done", done_n, 1);
  endtask

  task automatic t_slow_tick();
    tick_period = 3;
    run_seq(32'h1357_9BDF, 0, 1, 0, 1'b0, '0);
    check_run("slower tick rate (R5)", 32'h1357_9BDF, 3'b101);
    tick_period = 4;
  endtask

  task automatic t_overrun();
    chk(overrun == 0, "R7", "overrun clear before", overrun, 0);
    run_seq(32'hCAFE_F00D, 3, 1, 2, 1'b1, 32'h1111_2222);
    check_run("trigger while busy ignored (R7)", 32'hCAFE_F00D, 3'b000);
    chk(overrun == 1, "R7", "overrun set", overrun, 1);
    step(40);
    chk(busy == 0 && rise_n == NCH && ld_n == 1, "R7", "no restart after drop", rise_n, NCH);
    run_seq(32'h2468_ACE0, 1, 1, 1, 1'b0, '0);
    check_run("normal run after overrun", 32'h2468_ACE0, 3'b000);
    chk(overrun == 1, "R7", "overrun sticky", overrun, 1);
    do_reset();
    chk(overrun == 0, "R7", "overrun cleared by reset", overrun, 0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_all_start();
    t_all_timeout();
    t_err_hold();
    t_mixed();
    t_slow_tick();
    t_overrun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule